// File: doc/BRIEF.md
# Dual-Mode ADC Conversion Sequencer

This block is the digital side of a converter built from an external DAC and a comparator. On a start request it produces a series of trial codes for the DAC. It reads the comparator's verdict on each code and settles on an N-bit result. A mode input, sampled when the conversion is accepted, selects one of two searches. The ramp search steps the code up from zero one unit at a time. The binary search decides one bit per trial, beginning with the most significant bit.

Every trial code is held for one clock before the comparator is read, so that the DAC can settle. A trial therefore costs two cycles in either mode. A binary conversion takes a fixed 2·N cycles. A ramp conversion takes between four cycles and 2·2^N cycles, depending on the input level. The comparator input `cmp_hi_i` is high when the DAC output is above the analog input.

Top module: `adc_dual_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `trial_o`, `result_o`, `busy_o` and `done_o` all become zero.
- R2: When `start_i` is high while `busy_o` is low, a conversion is accepted at that edge. `busy_o` is high in the next cycle, and `mode_i` is latched for the whole conversion (0 = ramp, 1 = binary).
- R3: Each new trial code stays unchanged for one settle cycle. The comparator is read in the following cycle, so every trial lasts exactly two cycles.
- R4: In ramp mode the first trial code is 0. Each later trial is the previous code plus one. The conversion ends at the first trial where `cmp_hi_i` is high, and the result is that trial code.
- R5: In ramp mode, if the all-ones code is tried and `cmp_hi_i` stays low, the conversion ends with the all-ones result. The longest ramp conversion is therefore 2·2^N busy cycles.
- R6: In binary mode the first trial code has only the most significant bit set.
- R7: In binary mode, the bit under test is cleared when `cmp_hi_i` is high and kept when it is low. The next lower bit is then set and tried. The conversion ends after N trials (2·N busy cycles).
- R8: `done_o` is a single-cycle pulse. It rises in the same cycle that `busy_o` falls and is never high together with `busy_o`.
- R9: `result_o` changes only at the edge that raises `done_o`. It holds its value until the next conversion completes.
- R10: A `start_i` pulse while `busy_o` is high is ignored, whatever `mode_i` is. The running conversion keeps its mode, its length and its result.
- R11: A `start_i` pulse in the cycle where `done_o` is high is accepted as a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Conversion request |
| mode_i | input | 1 | Search select: 0 ramp, 1 binary |
| cmp_hi_i | input | 1 | Comparator: DAC output above analog input |
| trial_o | output | WIDTH | Trial code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Last completed conversion result |

## Verification
Two events can fall in the same cycle: the completion pulse of one conversion and the start request of the next. The bench provokes this by raising `start_i` in exactly the cycle where `done_o` is first seen. It then checks that `busy_o` is high one cycle later, and that the second conversion returns its own correct result and length. The opposite overlap is covered as well: start pulses with the other mode are driven into the middle of a running conversion. The bench checks that the result and the busy length match the original request. Around these cases, both modes are swept over every input level of the 8-bit configuration against a threshold comparator model.

// File: rtl/adc_seq_pkg.sv
// Shared types for the dual-mode conversion sequencer.
package adc_seq_pkg;
    // Sequencer phase: idle, DAC settle wait, comparator decision.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_DECIDE = 2'd2
    } phase_t;

    // Search selection, encoded as the mode input value.
    typedef enum logic {
        SRCH_RAMP   = 1'b0,
        SRCH_BINARY = 1'b1
    } search_t;
endpackage

// File: rtl/adc_seq_fsm.sv
// Phase controller for the conversion sequencer.
// Accepts a start only when idle, and alternates settle and decide phases
// until the datapath reports the final decision. It then pulses done for one cycle.
// Assumes: finish is only meaningful while decide is high.
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic finish,
    output logic load,
    output logic decide,
    output logic busy,
    output logic done
);
    phase_t phase_q, phase_d;

    assign load   = start && (phase_q == PH_IDLE);
    assign decide = (phase_q == PH_DECIDE);
    assign busy   = (phase_q != PH_IDLE);

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (load) phase_d = PH_SETTLE;
            PH_SETTLE: phase_d = PH_DECIDE;
            PH_DECIDE: phase_d = finish ? PH_IDLE : PH_SETTLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register and registered done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done    <= decide && finish;
        end
    end

    assert_start_to_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_settle_then_decide_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SETTLE) |=> (phase_q == PH_DECIDE));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && phase_q == PH_SETTLE) |=> (phase_q == PH_DECIDE));
endmodule

// File: rtl/adc_trial_path.sv
// Trial-code datapath for both search modes.
// Holds the current trial code, the one-hot mask of the bit under test and the
// latched mode. It steps the code on each decide phase and captures the result.
// Assumes: cmp_hi is already settled for the current code whenever decide is high.
module adc_trial_path
    import adc_seq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             decide,
    input  logic             mode_in,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] trial,
    output logic             finish,
    output logic [WIDTH-1:0] result
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] TOP_BIT  = {1'b1, {(WIDTH-1){1'b0}}};

    search_t          mode_q;
    logic [WIDTH-1:0] trial_q, mask_q, result_q;
    logic [WIDTH-1:0] binary_kept, final_code, step_code;

    // Binary search: clear the bit under test if the DAC overshot.
    assign binary_kept = cmp_hi ? (trial_q & ~mask_q) : trial_q;

    // End-of-conversion decision and the value it commits.
    always_comb begin
        if (mode_q == SRCH_RAMP) begin
            finish     = decide && (cmp_hi || trial_q == ALL_ONES);
            final_code = trial_q;
            step_code  = trial_q + 1'b1;
        end else begin
            finish     = decide && mask_q[0];
            final_code = binary_kept;
            step_code  = binary_kept | (mask_q >> 1);
        end
    end

    // Trial code, bit mask and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_q <= '0;
            mask_q  <= '0;
            mode_q  <= SRCH_RAMP;
        end else if (load) begin
            mode_q  <= search_t'(mode_in);
            mask_q  <= TOP_BIT;
            trial_q <= mode_in ? TOP_BIT : '0;
        end else if (decide && !finish) begin
            trial_q <= step_code;
            mask_q  <= mask_q >> 1;
        end
    end

    // Result register, written once per completed conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (finish)
            result_q <= final_code;
    end

    assign trial  = trial_q;
    assign result = result_q;

    assert_ramp_increment_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && mode_q == SRCH_RAMP && !finish) |=> (trial_q == $past(trial_q) + 1'b1));
    assert_ramp_all_ones_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && mode_q == SRCH_RAMP && trial_q == ALL_ONES) |=> (result_q == ALL_ONES));
    assert_binary_first_trial_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode_in) |=> (trial_q == TOP_BIT));
    assert_binary_clear_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && mode_q == SRCH_BINARY && cmp_hi && !mask_q[0])
            |=> ((trial_q & $past(mask_q)) == '0));
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(result_q));
endmodule

// File: rtl/adc_dual_seq.sv
// Top of the dual-mode conversion sequencer.
// Connects the phase controller to the trial-code datapath.
// Assumes: an external DAC converts trial_o, and cmp_hi_i reports the
// comparator one settle cycle after each code change.
module adc_dual_seq #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic             cmp_hi_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    logic load, decide, finish;

    adc_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_i),
        .finish (finish),
        .load   (load),
        .decide (decide),
        .busy   (busy_o),
        .done   (done_o)
    );

    adc_trial_path #(.WIDTH(WIDTH)) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .decide  (decide),
        .mode_in (mode_i),
        .cmp_hi  (cmp_hi_i),
        .trial   (trial_o),
        .finish  (finish),
        .result  (result_o)
    );

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: tb/test_adc_dual_seq.sv
module test_adc_dual_seq;
    localparam int WIDTH = 8;
    localparam int MAXV  = (1 << WIDTH) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic [WIDTH-1:0] trial, result;
    logic busy, done;
    int vin = 0;
    logic cmp_hi;
    int n_checks = 0, n_fail = 0, busy_cnt = 0, cycles = 0;

    always #2 clk = ~clk; // 250 MHz

    // Comparator model: DAC output above the analog level.
    assign cmp_hi = (int'(trial) > vin);

    adc_dual_seq #(.WIDTH(WIDTH)) i_adc_dual_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .cmp_hi_i(cmp_hi),
        .trial_o(trial), .busy_o(busy), .done_o(done), .result_o(result)
    );

    // Busy-cycle counter, cleared by each launch.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (busy) busy_cnt <= busy_cnt + 1;
    end

    // Watchdog.
    always @(posedge clk) if (cycles > 190000) begin
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive a start from a negedge and return at the next negedge.
    task automatic launch(input logic m, input int v);
        vin = v; mode = m; start = 1'b1; busy_cnt = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for done and check the result and the busy length.
    task automatic finish_conv(input int exp_res, input int exp_cyc, input string tag);
        int guard = 0;
        while (!done && guard < 2 * (MAXV + 1) + 20) begin
            @(negedge clk);
            guard++;
        end
        chk(done === 1'b1, {tag, " done seen"}, int'(done), 1);
        chk(int'(result) == exp_res, {tag, " result"}, int'(result), exp_res);
        chk(busy_cnt == exp_cyc, {tag, " busy cycles"}, busy_cnt, exp_cyc);
    endtask

    function automatic int ramp_res(input int v);
        return (v == MAXV) ? MAXV : v + 1;
    endfunction
    function automatic int ramp_cyc(input int v);
        return (v == MAXV) ? 2 * (MAXV + 1) : 2 * (v + 2);
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(trial == 0 && result == 0, "R1 trial/result reset", int'(trial) + int'(result), 0);
        chk(busy == 0 && done == 0, "R1 busy/done reset", int'(busy) + int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R5 ramp sweep over every level, with R3 settle and R8/R9 pulse checks
        for (int v = 0; v <= MAXV; v++) begin
            launch(1'b0, v);
            chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
            chk(trial == 0, "R4 ramp first code", int'(trial), 0);
            @(negedge clk);
            chk(trial == 0, "R3 code held through settle", int'(trial), 0);
            @(negedge clk);
            chk(trial == 1, "R4 ramp steps by one", int'(trial), 1);
            finish_conv(ramp_res(v), ramp_cyc(v), (v == MAXV) ? "R5 ramp top" : "R4 ramp");
            chk(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
            @(negedge clk);
            chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
            chk(int'(result) == ramp_res(v), "R9 result held", int'(result), ramp_res(v));
        end

        // R6/R7 binary sweep over every level
        for (int v = 0; v <= MAXV; v++) begin
            launch(1'b1, v);
            chk(int'(trial) == (1 << (WIDTH - 1)), "R6 binary first code", int'(trial), 1 << (WIDTH - 1));
            finish_conv(v, 2 * WIDTH, "R7 binary");
            @(negedge clk);
            chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
        end

        // R10: start pulses with the other mode during a binary conversion
        launch(1'b1, 100);
        @(negedge clk);
        mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_conv(100, 2 * WIDTH, "R10 start ignored while busy");
        @(negedge clk);
        chk(busy == 1'b0, "R10 no hidden restart", int'(busy), 0);

        // R10: binary start during a ramp conversion
        launch(1'b0, 20);
        repeat (3) @(negedge clk);
        mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_conv(21, ramp_cyc(20), "R10 ramp keeps mode");

        // R11: start in the done cycle, chained through several conversions
        launch(1'b1, 37);
        finish_conv(37, 2 * WIDTH, "R11 first of chain");
        launch(1'b0, 5);
        chk(busy == 1'b1, "R11 start in done cycle accepted", int'(busy), 1);
        finish_conv(6, ramp_cyc(5), "R11 chained ramp");
        launch(1'b1, MAXV);
        chk(busy == 1'b1, "R11 second chained start", int'(busy), 1);
        finish_conv(MAXV, 2 * WIDTH, "R11 chained binary");
        @(negedge clk);
        chk(int'(result) == MAXV, "R9 result held after chain", int'(result), MAXV);

        // R1: reset mid-conversion returns to the reset state
        launch(1'b0, 200);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && trial == 0 && result == 0, "R1 reset mid-run",
            int'(busy) + int'(trial) + int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule